// File: doc/BRIEF.md
# Zero-suppressed hit packet formatter

This block sits at the edge of a pixel-detector readout. It takes one record per pixel that registered a hit and formats it as a 48-bit output word. Pixels without a hit never reach it, so the output carries only real hits. Each hit record has a double-column index, a super-pixel index, a pixel index and a 28-bit data word.

The block runs in one of two readout styles, chosen by `mode_dd`. In frame-based mode (`mode_dd`=0), a frame-end strobe closes the frame. All hits accepted up to and including the strobe cycle go out first, then one end-of-command word. In data-driven mode (`mode_dd`=1), hits stream out continuously, and an end-of-command word is sent only when a stop is requested. The end-of-command word carries the chip identifier so that downstream logic can tag the data.

One output register drives a valid/ready stream. The block takes one new word per cycle while the sink keeps up, and it holds its word unchanged while the sink stalls.

Top module: `hit_pkt_fmt`

## Requirements
- R1: While and after reset, `pkt_valid` is 0 and `hit_ready` is 1.
- R2: A hit word is laid out as follows: bits 47:44 header, 43:37 double-column index, 36:31 super-pixel index, 30:28 pixel index, 27:0 pixel data.
- R3: The hit header is 0xA when `mode_dd` is 0 and 0xB when it is 1, taken in the cycle the hit is accepted.
- R4: An end-of-command word has 0x71 in bits 47:40. Bits 39:32 are 0xA0 in frame mode or 0xB0 in data-driven mode. Bits 31:0 hold `chip_id`, taken in the cycle the word is loaded.
- R5: In frame mode, `frame_end` makes an end-of-command word pending. It follows every hit accepted up to and including the strobe cycle, and `hit_ready` stays low until the word has been loaded.
- R6: `stop_req` is the only closing strobe in data-driven mode and `frame_end` is the only one in frame mode; the other strobe has no effect.
- R7: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_data` and `pkt_valid` hold, and `hit_ready` is 0.
- R8: Every accepted hit appears on the output exactly once, in the order accepted.
- R9: A hit accepted at one clock edge is presented at the next, and one word per cycle passes while `pkt_ready` stays 1.
- R10: A closing strobe that arrives while an end-of-command word is already pending, or in the cycle it is loaded, adds no second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dd | input | 1 | 0 frame-based, 1 data-driven |
| chip_id | input | 32 | Chip identifier placed in end-of-command words |
| frame_end | input | 1 | Frame-closing strobe (frame mode) |
| stop_req | input | 1 | Stop strobe (data-driven mode) |
| hit_valid | input | 1 | Hit record present |
| hit_ready | output | 1 | Hit record accepted when high with hit_valid |
| hit_dcol | input | 7 | Double-column index |
| hit_spix | input | 6 | Super-pixel index |
| hit_pix | input | 3 | Pixel index within super-pixel |
| hit_data | input | 28 | Pixel data |
| pkt_valid | output | 1 | Output word present |
| pkt_ready | input | 1 | Sink accepts output word |
| pkt_data | output | 48 | Output word |

## Verification
The hardest case to reach is a closing strobe that lands in the same cycle as a hit, with another hit already waiting behind it. The stimulus asserts `frame_end` together with the second of two back-to-back hits and keeps a third hit valid. The third hit must then come out after the end-of-command word. Separate directed sequences stall the sink while a hit waits and repeat a strobe across two cycles. They also pulse the strobe that does not belong to the current mode.

// File: rtl/hit_pkt_fmt.sv
module hit_pkt_fmt #(
  parameter logic [3:0] HDR_FRAME = 4'hA,
  parameter logic [3:0] HDR_DD    = 4'hB,
  parameter logic [7:0] EOC_TAG   = 8'h71
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_dd,
  input  logic [31:0] chip_id,
  input  logic        frame_end,
  input  logic        stop_req,
  input  logic        hit_valid,
  output logic        hit_ready,
  input  logic [6:0]  hit_dcol,
  input  logic [5:0]  hit_spix,
  input  logic [2:0]  hit_pix,
  input  logic [27:0] hit_data,
  output logic        pkt_valid,
  input  logic        pkt_ready,
  output logic [47:0] pkt_data
);

  logic        out_v;
  logic [47:0] out_q;
  logic        eoc_pend;

  wire        slot_free = !out_v || pkt_ready;
  wire        hit_fire  = hit_valid && hit_ready;
  wire        eoc_fire  = eoc_pend && slot_free;
  wire        end_req   = mode_dd ? stop_req : frame_end;
  wire [3:0]  hdr       = mode_dd ? HDR_DD : HDR_FRAME;
  wire [47:0] hit_word  = {hdr, hit_dcol, hit_spix, hit_pix, hit_data};
  wire [47:0] eoc_word  = {EOC_TAG, hdr, 4'h0, chip_id};

  assign hit_ready = !eoc_pend && slot_free;
  assign pkt_valid = out_v;
  assign pkt_data  = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_q    <= '0;
      eoc_pend <= 1'b0;
    end else begin
      if (hit_fire) begin
        out_q <= hit_word;
        out_v <= 1'b1;
      end else if (eoc_fire) begin
        out_q <= eoc_word;
        out_v <= 1'b1;
      end else if (pkt_ready) begin
        out_v <= 1'b0;
      end
      if (eoc_fire)     eoc_pend <= 1'b0;
      else if (end_req) eoc_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/hit_pkt_fmt_chk.sv
module hit_pkt_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_dd,
  input logic        hit_valid,
  input logic        hit_ready,
  input logic [27:0] hit_data,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic [47:0] pkt_data
);

  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data));

  a_r7_no_accept_full: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |-> !hit_ready);

  a_r9_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready |=> pkt_valid && pkt_data[27:0] == $past(hit_data));

  a_r3_header: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready |=> pkt_data[47:44] == ($past(mode_dd) ? 4'hB : 4'hA));

  a_r4_eoc_mode_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_data[47:40] == 8'h71 |-> pkt_data[39:32] == 8'hA0 || pkt_data[39:32] == 8'hB0);

endmodule

bind hit_pkt_fmt hit_pkt_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_dd(mode_dd), .hit_valid(hit_valid),
  .hit_ready(hit_ready), .hit_data(hit_data), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_data(pkt_data)
);

// File: tb/sim_hit_pkt_fmt.sv
`timescale 1ns/1ps
module sim_hit_pkt_fmt;
  logic clk = 0, rst_n = 0, mode_dd = 0, frame_end = 0, stop_req = 0;
  logic hit_valid = 0, pkt_ready = 1;
  logic [31:0] chip_id = 32'hC0FFEE01;
  logic [6:0] hit_dcol = 0;
  logic [5:0] hit_spix = 0;
  logic [2:0] hit_pix = 0;
  logic [27:0] hit_data = 0;
  logic hit_ready, pkt_valid;
  logic [47:0] pkt_data;
  int checks = 0, errors = 0, ncap = 0;
  bit done = 0;
  logic [47:0] cap [64];

  always #4 clk = ~clk;

  hit_pkt_fmt u0 (.clk, .rst_n, .mode_dd, .chip_id, .frame_end, .stop_req,
    .hit_valid, .hit_ready, .hit_dcol, .hit_spix, .hit_pix, .hit_data,
    .pkt_valid, .pkt_ready, .pkt_data);

  always @(posedge clk)
    if (rst_n && pkt_valid && pkt_ready && ncap < 64) begin
      cap[ncap] = pkt_data;
      ncap++;
    end

  // {mode, expected header, dcol, spix, pix, data}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 4'hA, 7'd0,   6'd0,  3'd0, 28'h0000000},
    {1'b0, 4'hA, 7'd127, 6'd63, 3'd7, 28'hFFFFFFF},
    {1'b0, 4'hA, 7'd1,   6'd0,  3'd4, 28'h0000001},
    {1'b1, 4'hB, 7'd64,  6'd32, 3'd1, 28'h8000000},
    {1'b1, 4'hB, 7'd5,   6'd17, 3'd2, 28'h1234567},
    {1'b1, 4'hB, 7'd127, 6'd0,  3'd7, 28'hABCDEF0},
    {1'b0, 4'hA, 7'd42,  6'd21, 3'd5, 28'h5555555},
    {1'b1, 4'hB, 7'd0,   6'd63, 3'd0, 28'hAAAAAAA}
  };

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_hit(input logic [6:0] d, input logic [5:0] s, input logic [2:0] p, input logic [27:0] x);
    hit_dcol = d; hit_spix = s; hit_pix = p; hit_data = x; hit_valid = 1;
  endtask

  function automatic logic [47:0] hw(input logic [3:0] h, input logic [6:0] d,
      input logic [5:0] s, input logic [2:0] p, input logic [27:0] x);
    return {h, d, s, p, x};
  endfunction

  initial begin
    #(8*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 48'h0, 48'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [47:0] held;
    repeat (3) @(negedge clk);
    chk(pkt_valid == 0, "R1 valid in reset", {47'b0, pkt_valid}, 48'h0);
    rst_n = 1;
    @(negedge clk);
    chk(pkt_valid == 0 && hit_ready == 1, "R1 after reset", {46'b0, pkt_valid, hit_ready}, 48'h1);

    // R2 R3 R9 table walk
    for (int i = 0; i < 8; i++) begin
      mode_dd = VEC[i][48];
      put_hit(VEC[i][43:37], VEC[i][36:31], VEC[i][30:28], VEC[i][27:0]);
      @(negedge clk);
      hit_valid = 0;
      chk(pkt_valid && pkt_data == VEC[i][47:0], "R2 R3 R9 hit word", pkt_data, VEC[i][47:0]);
    end
    @(negedge clk);
    chk(pkt_valid == 0, "R9 drained", {47'b0, pkt_valid}, 48'h0);

    // R5 R8: strobe with second hit, third hit waits
    mode_dd = 0; n0 = ncap;
    put_hit(7'd3, 6'd4, 3'd5, 28'h0000111);
    @(negedge clk);
    put_hit(7'd6, 6'd7, 3'd1, 28'h0000222); frame_end = 1;
    @(negedge clk);
    frame_end = 0; put_hit(7'd9, 6'd9, 3'd2, 28'h0000333);
    chk(hit_ready == 0, "R5 ready low while pending", {47'b0, hit_ready}, 48'h0);
    @(negedge clk); @(negedge clk);
    hit_valid = 0;
    repeat (2) @(negedge clk);
    chk(ncap - n0 == 4, "R8 count", 48'(ncap - n0), 48'd4);
    chk(cap[n0] == hw(4'hA, 7'd3, 6'd4, 3'd5, 28'h111), "R8 first", cap[n0], hw(4'hA, 7'd3, 6'd4, 3'd5, 28'h111));
    chk(cap[n0+1] == hw(4'hA, 7'd6, 6'd7, 3'd1, 28'h222), "R5 strobe-cycle hit before end", cap[n0+1], hw(4'hA, 7'd6, 6'd7, 3'd1, 28'h222));
    chk(cap[n0+2] == {8'h71, 8'hA0, 32'hC0FFEE01}, "R4 R5 frame end word", cap[n0+2], {8'h71, 8'hA0, 32'hC0FFEE01});
    chk(cap[n0+3] == hw(4'hA, 7'd9, 6'd9, 3'd2, 28'h333), "R5 later hit after end", cap[n0+3], hw(4'hA, 7'd9, 6'd9, 3'd2, 28'h333));

    // R7 stall
    n0 = ncap; pkt_ready = 0;
    put_hit(7'd10, 6'd11, 3'd3, 28'h0000444);
    @(negedge clk);
    put_hit(7'd12, 6'd13, 3'd6, 28'h0000555);
    held = pkt_data;
    chk(hit_ready == 0, "R7 no accept while stalled", {47'b0, hit_ready}, 48'h0);
    repeat (3) @(negedge clk);
    chk(pkt_valid && pkt_data == held, "R7 word held", pkt_data, held);
    pkt_ready = 1;
    @(negedge clk);
    hit_valid = 0;
    repeat (2) @(negedge clk);
    chk(ncap - n0 == 2 && cap[n0+1] == hw(4'hA, 7'd12, 6'd13, 3'd6, 28'h555), "R7 R8 order after stall",
        cap[n0+1], hw(4'hA, 7'd12, 6'd13, 3'd6, 28'h555));

    // R6 data-driven: frame_end ignored, stop_req closes
    mode_dd = 1; n0 = ncap; chip_id = 32'h0BADF00D;
    frame_end = 1; @(negedge clk); frame_end = 0;
    repeat (3) @(negedge clk);
    chk(ncap == n0 && hit_ready == 1, "R6 frame_end ignored in data-driven", 48'(ncap - n0), 48'd0);
    stop_req = 1; @(negedge clk); @(negedge clk); stop_req = 0;
    repeat (3) @(negedge clk);
    chk(ncap - n0 == 1, "R10 one end word for repeated strobe", 48'(ncap - n0), 48'd1);
    chk(cap[n0] == {8'h71, 8'hB0, 32'h0BADF00D}, "R4 R6 data-driven end word", cap[n0], {8'h71, 8'hB0, 32'h0BADF00D});

    // R6 frame mode ignores stop_req
    mode_dd = 0; n0 = ncap;
    stop_req = 1; @(negedge clk); stop_req = 0;
    repeat (3) @(negedge clk);
    chk(ncap == n0 && hit_ready == 1, "R6 stop_req ignored in frame mode", 48'(ncap - n0), 48'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule